// File: doc/BRIEF.md
# Sixteen-Channel Hertz-Programmed PWM Bank

This block drives a bank of independent pulse-width outputs. Software sets two 16-bit values for each channel: a rate in hertz and a duty word. The duty word gives the high share of the period as a fraction of full scale. The block turns these values into clock-tick counts. Each period length is the system clock rate divided by the programmed rate. Each high time is that period scaled by the duty word. Every period starts with its high phase.

One divider is shared by all channels and runs sequentially. It recomputes a channel's tick counts after any write to that channel, and it puts the results in a shadow stage. The live counts take the shadow values only when that channel's current period ends. Reprogramming therefore never cuts or stretches a pulse. The stored register values can always be read back, and reads have no effect on the outputs.

Top module: `pwm_bank`

## Requirements
- R1: After reset every channel reads back rate 400 and duty 0, and every output is low.
- R2: Register address bit 0 selects the field (0 = rate, 1 = duty) and the upper address bits give the channel number. A read of an address returns, in the same cycle, the last value written there.
- R3: A channel with a nonzero rate f repeats its waveform every floor(CLK_HZ / f) clock ticks.
- R4: When the duty word d is not 0xFFFF, the output is high for the first floor(P * d / 65536) ticks of each period of P ticks. With CLK_HZ = 1 MHz, a rate of 100 and a duty of 1823 give 278 high ticks out of 10000.
- R5: A duty word of 0 holds the output low at all times.
- R6: A duty word of 0xFFFF holds the output high for the whole period, with no low tick.
- R7: A rate of 0 holds the output low and stops the channel's counter. Writing a nonzero rate later restarts the channel with the new tick counts.
- R8: A write never changes the period that is in progress. The period and high time in force at its start run to the end, and the new values apply from the next period.
- R9: A write to one channel leaves the waveform of every other channel unchanged.
- R10: When several writes come back to back, to one channel or to several, each channel settles on the tick counts of the last values written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | AW | Write address {channel, field} |
| wr_data | input | 16 | Write value |
| rd_addr | input | AW | Read address {channel, field} |
| rd_data | output | 16 | Stored value at rd_addr |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The checker watches several things on every cycle for every channel. A stopped channel stays low, and a zero high time gives a low output. A full high time gives an output that is high. The high count never exceeds the period, and the counter stays inside its period. The live tick counts hold steady except at a period wrap. Every write lands in the addressed register. Only the bench scenarios can show the arithmetic itself: the measured period and high lengths for different rates and duties, the worked example of 278 ticks, and the way queued recomputations settle on the last value written. They also show that a duty change made partway through a high phase leaves that pulse at its old length.

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH = 16,
  parameter int CLK_HZ = 50_000_000,
  parameter int RW = 16,
  parameter int RST_FREQ = 400,
  localparam int CW = $clog2(NCH),
  localparam int AW = CW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [RW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [RW-1:0]  rd_data,
  output logic [NCH-1:0] pwm_out
);
  localparam int PW = $clog2(CLK_HZ + 1);
  localparam int SW = $clog2(PW);
  localparam logic [PW-1:0] DIVIDEND = PW'(CLK_HZ);
  localparam logic [PW-1:0] RST_PER = PW'(CLK_HZ / RST_FREQ);
  localparam logic [RW-1:0] FULL = '1;

  logic [NCH-1:0][RW-1:0] freq_q, duty_q;
  logic [NCH-1:0][PW-1:0] per_cur, per_nxt, hi_cur, hi_nxt, cnt;
  logic [NCH-1:0] pend, dirty, upd, wrap;

  logic          busy, pick_vld;
  logic [CW-1:0] sel_ch, pick;
  logic [SW-1:0] bi;
  logic [RW-1:0] rem, dv, dty;
  logic [PW-1:0] quo;

  wire [CW-1:0] wr_ch = wr_addr[AW-1:1];
  wire [CW-1:0] rd_ch = rd_addr[AW-1:1];

  assign rd_data = rd_addr[0] ? duty_q[rd_ch] : freq_q[rd_ch];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        freq_q[i] <= RW'(RST_FREQ);
        duty_q[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr[0]) duty_q[wr_ch] <= wr_data;
      else            freq_q[wr_ch] <= wr_data;
    end
  end

  always_comb begin
    pick = '0;
    pick_vld = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (dirty[i]) begin
        pick = CW'(i);
        pick_vld = 1'b1;
      end
    end
  end

  wire [RW:0] trial = {rem, DIVIDEND[bi]};
  wire        ge = trial >= {1'b0, dv};
  wire        last = busy && (bi == '0);
  wire [PW-1:0] per_new = (dv == '0) ? '0 : {quo[PW-2:0], ge};
  logic [PW+RW-1:0] prod;
  assign prod = {{RW{1'b0}}, per_new} * {{PW{1'b0}}, dty};
  wire [PW-1:0] hi_new = (dty == FULL) ? per_new : prod[PW+RW-1:RW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      dirty <= '0;
      sel_ch <= '0;
      bi <= '0;
      rem <= '0;
      quo <= '0;
      dv <= '0;
      dty <= '0;
    end else begin
      if (busy) begin
        rem <= ge ? RW'(trial - {1'b0, dv}) : trial[RW-1:0];
        quo <= {quo[PW-2:0], ge};
        bi <= bi - 1'b1;
        if (bi == '0) busy <= 1'b0;
      end else if (pick_vld) begin
        busy <= 1'b1;
        sel_ch <= pick;
        dv <= freq_q[pick];
        dty <= duty_q[pick];
        rem <= '0;
        quo <= '0;
        bi <= SW'(PW - 1);
        dirty[pick] <= 1'b0;
      end
      if (wr_en) dirty[wr_ch] <= 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign upd[g] = last && (sel_ch == CW'(g));
    assign wrap[g] = (per_cur[g] == '0) || (cnt[g] == per_cur[g] - 1'b1);
    assign pwm_out[g] = cnt[g] < hi_cur[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        per_cur[i] <= RST_PER;
        hi_cur[i] <= '0;
        per_nxt[i] <= '0;
        hi_nxt[i] <= '0;
        cnt[i] <= '0;
      end
      pend <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (upd[i]) begin
          per_nxt[i] <= per_new;
          hi_nxt[i] <= hi_new;
          pend[i] <= 1'b1;
        end else if (wrap[i] && pend[i]) begin
          per_cur[i] <= per_nxt[i];
          hi_cur[i] <= hi_nxt[i];
          pend[i] <= 1'b0;
        end
        if (wrap[i]) cnt[i] <= '0;
        else         cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH = 16,
  parameter int PW = 26,
  parameter int RW = 16,
  parameter int AW = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic [RW-1:0]          wr_data,
  input logic [NCH-1:0][RW-1:0] freq_q,
  input logic [NCH-1:0][RW-1:0] duty_q,
  input logic [NCH-1:0][PW-1:0] per_cur,
  input logic [NCH-1:0][PW-1:0] hi_cur,
  input logic [NCH-1:0][PW-1:0] cnt,
  input logic [NCH-1:0]         pwm_out
);
  for (genvar g = 0; g < NCH; g++) begin : g_a
    // R7
    stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_cur[g] == '0 |-> !pwm_out[g]);
    // R5
    zero_high_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_cur[g] == '0 |-> !pwm_out[g]);
    // R6
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (per_cur[g] != '0 && hi_cur[g] == per_cur[g]) |-> pwm_out[g]);
    // R4
    hi_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_cur[g] <= per_cur[g]);
    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_cur[g] != '0 |-> cnt[g] < per_cur[g]);
    // R8
    hold_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (per_cur[g] != '0 && cnt[g] != per_cur[g] - 1'b1)
        |=> ($stable(per_cur[g]) && $stable(hi_cur[g])));
    // R2
    freq_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(2 * g)) |=> freq_q[g] == $past(wr_data));
    // R2
    duty_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(2 * g + 1)) |=> duty_q[g] == $past(wr_data));
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .PW(PW), .RW(RW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .freq_q(freq_q), .duty_q(duty_q), .per_cur(per_cur), .hi_cur(hi_cur),
  .cnt(cnt), .pwm_out(pwm_out)
);

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int HZ = 1_000_000;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [NCH-1:0] pwm_out;
  int checks = 0;
  int failures = 0;

  pwm_bank #(.NCH(NCH), .CLK_HZ(HZ)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int exp_per(input int f);
    return (f == 0) ? 0 : HZ / f;
  endfunction

  function automatic int exp_hi(input int f, input int d);
    longint p;
    p = exp_per(f);
    if (d == 16'hFFFF) return int'(p);
    return int'((p * d) >> 16);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input bit fld, input int val);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = AW'(2 * ch + int'(fld));
    wr_data = 16'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input bit fld, output int val);
    @(negedge clk);
    rd_addr = AW'(2 * ch + int'(fld));
    #1;
    val = int'(rd_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int ch, output int hi, output int per);
    int n = 0;
    @(negedge clk);
    while (pwm_out[ch] && n < 30000) begin @(negedge clk); n++; end
    while (!pwm_out[ch] && n < 60000) begin @(negedge clk); n++; end
    hi = 0;
    while (pwm_out[ch] && hi < 30000) begin @(negedge clk); hi++; end
    per = hi;
    while (!pwm_out[ch] && per < 30000) begin @(negedge clk); per++; end
  endtask

  task automatic count_high(input int ch, input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) highs++;
    end
  endtask

  task automatic t_reset;
    int v, h;
    for (int c = 0; c < NCH; c++) begin
      rd(c, 1'b0, v); chk("R1 reset rate", v, 400);
      rd(c, 1'b1, v); chk("R1 reset duty", v, 0);
    end
    chk("R1 outputs low", int'(pwm_out), 0);
    count_high(0, 3000, h);
    chk("R5 reset duty 0 stays low", h, 0);
  endtask

  task automatic t_readback;
    int v;
    wr(12, 1'b0, 16'hA5C3);
    wr(12, 1'b1, 16'h1234);
    rd(12, 1'b0, v); chk("R2 rate readback", v, 16'hA5C3);
    rd(12, 1'b1, v); chk("R2 duty readback", v, 16'h1234);
    rd(11, 1'b1, v); chk("R2 neighbour untouched", v, 0);
    wr(12, 1'b0, 0);
    wr(12, 1'b1, 0);
  endtask

  task automatic t_basic;
    int h, p;
    wr(3, 1'b0, 1000);
    wr(3, 1'b1, 16'h8000);
    wr(5, 1'b0, 3000);
    wr(5, 1'b1, 16'h4000);
    idle(3000);
    measure(3, h, p);
    chk("R3 ch3 period", p, exp_per(1000));
    chk("R4 ch3 high", h, exp_hi(1000, 16'h8000));
    measure(5, h, p);
    chk("R10 ch5 period", p, exp_per(3000));
    chk("R4 ch5 high", h, exp_hi(3000, 16'h4000));
  endtask

  task automatic t_example;
    int h, p;
    wr(1, 1'b0, 100);
    wr(1, 1'b1, 1823);
    idle(3000);
    measure(1, h, p);
    chk("R3 example period", p, 10000);
    chk("R4 example high", h, 278);
  endtask

  task automatic t_boundary;
    int h, p, n;
    n = 0;
    @(negedge clk);
    while (pwm_out[3] && n < 5000) begin @(negedge clk); n++; end
    while (!pwm_out[3] && n < 5000) begin @(negedge clk); n++; end
    h = 0;
    repeat (100) begin @(negedge clk); h++; end
    wr_en = 1'b1;
    wr_addr = AW'(7);
    wr_data = 16'h1000;
    @(negedge clk);
    wr_en = 1'b0;
    h++;
    while (pwm_out[3] && h < 5000) begin @(negedge clk); h++; end
    chk("R8 pulse in progress keeps old length", h, exp_hi(1000, 16'h8000));
    measure(3, h, p);
    chk("R8 next period uses new duty", h, exp_hi(1000, 16'h1000));
    chk("R8 period unchanged", p, exp_per(1000));
  endtask

  task automatic t_indep;
    int h, p;
    measure(5, h, p);
    chk("R9 ch5 period kept", p, exp_per(3000));
    chk("R9 ch5 high kept", h, exp_hi(3000, 16'h4000));
  endtask

  task automatic t_full;
    int h;
    wr(7, 1'b0, 1000);
    wr(7, 1'b1, 16'hFFFF);
    idle(2500);
    count_high(7, 3000, h);
    chk("R6 full duty always high", h, 3000);
  endtask

  task automatic t_stop;
    int h, p;
    wr(3, 1'b0, 0);
    idle(2500);
    count_high(3, 3000, h);
    chk("R7 rate 0 low", h, 0);
    wr(3, 1'b0, 2000);
    idle(1500);
    measure(3, h, p);
    chk("R7 restart period", p, exp_per(2000));
    chk("R7 restart high", h, exp_hi(2000, 16'h1000));
  endtask

  task automatic t_duty0;
    int h;
    wr(5, 1'b1, 0);
    idle(1000);
    count_high(5, 3000, h);
    chk("R5 duty 0 low", h, 0);
  endtask

  task automatic t_burst;
    int h, p;
    wr(9, 1'b0, 500);
    wr(9, 1'b1, 16'h2000);
    wr(9, 1'b0, 2000);
    wr(9, 1'b1, 16'h8000);
    idle(5000);
    measure(9, h, p);
    chk("R10 last rate wins", p, exp_per(2000));
    chk("R10 last duty wins", h, exp_hi(2000, 16'h8000));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_readback();
    t_basic();
    t_example();
    t_boundary();
    t_indep();
    t_full();
    t_stop();
    t_duty0();
    t_burst();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule